// File: doc/BRIEF.md
# Double-Buffered Endpoint Descriptor Locator

This block sits beside the packet engine of a USB device controller that serves up to 16 endpoints, each with an OUT and an IN direction. For every endpoint/direction pair it keeps one parity bit that selects between the two descriptor slots of a double-buffered pair, called Even and Odd. A completed transaction flips that parity bit. A lookup port turns an endpoint number and a direction into the index of the descriptor that serves them next, and into that descriptor's byte address in buffer RAM.

A 2-bit mode input selects which pairs are double buffered. The mode therefore also sets how descriptors are packed in the table. The table is ordered by endpoint, with OUT ahead of IN, and with Even ahead of Odd inside each double-buffered pair. Software can clear every parity bit with a one-cycle pulse. Disabling the block also clears them. A status output keeps the parity that the most recently completed transaction used.

Top module: `usb_ppbd_addresser`

## Requirements
- R1: After reset, `last_odd` is 0 and every lookup returns the Even descriptor of its pair.
- R2: Mode code 00 means no pair is double buffered, and the index is 2·ep + dir (dir: 0 = OUT, 1 = IN).
- R3: Mode code 01 double buffers only endpoint 0 OUT. Endpoint 0 OUT maps to index 0 (Even) or 1 (Odd). Endpoint 0 IN maps to 2. Every other endpoint maps to 2·ep + dir + 1.
- R4: Mode code 10 double buffers every pair, and the index is 4·ep + 2·dir + parity. A completion flips the parity of the completing pair only.
- R5: Mode code 11 double buffers every pair except those of endpoint 0. Endpoint 0 maps to index dir. Endpoint ep ≥ 1 maps to 2 + 4·(ep−1) + 2·dir + parity.
- R6: A completion on a pair that is not double buffered leaves all parities unchanged, and it sets `last_odd` to 0.
- R7: On a completion that is accepted, `last_odd` takes the parity that the completing pair held before the flip. It is visible from the next cycle.
- R8: A `swrst` pulse returns every parity to Even. A completion in the same cycle has no effect on the parities or on `last_odd`.
- R9: When `mode` changes while `enable` is high, every parity returns to Even. A completion in the cycle of the change is dropped.
- R10: `look_addr` equals 0x400 + 4·`look_idx`.
- R11: `look_idx` stays below the descriptor count of the mode: 32, 33, 64 or 62 for codes 00, 01, 10 or 11.
- R12: While `enable` is low, every parity is held at Even and completions are ignored, so the block starts from Even once it is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; low holds all parities at Even |
| mode | input | 2 | Double-buffering mode code |
| done_vld | input | 1 | One-cycle pulse: a transaction has completed |
| done_ep | input | 4 | Endpoint of the completed transaction |
| done_dir | input | 1 | Direction of the completed transaction (0 OUT, 1 IN) |
| swrst | input | 1 | Software pulse that clears all parities to Even |
| look_ep | input | 4 | Endpoint to look up |
| look_dir | input | 1 | Direction to look up |
| look_idx | output | 6 | Descriptor index for the looked-up pair |
| look_addr | output | 16 | Byte address of that descriptor |
| last_odd | output | 1 | Parity used by the last accepted completion |

## Verification
The case that is hardest to reach from the ports is a completion that lands in the same cycle as a clearing event: a software clear, a mode write or a disable. Each of these can only be seen to take effect once pairs already sit on Odd. The stimulus therefore first drives a pseudo-random run of completions in mode 10 until many parities are Odd. It then raises the completion strobe in exactly the cycle of each clearing event, and sweeps all 32 lookups to show that every pair is back on Even and that `last_odd` kept its earlier value. Every mode gets its own run of completions and a full lookup sweep, so that high endpoints in mode 11 are also seen on Odd.

// File: rtl/usb_ppbd_pkg.sv
package usb_ppbd_pkg;

   typedef enum logic [1:0] {
      PB_NONE    = 2'b00,
      PB_EP0_OUT = 2'b01,
      PB_ALL     = 2'b10,
      PB_NOT_EP0 = 2'b11
   } pb_mode_e;

   // Whether a given endpoint/direction pair owns an Even/Odd descriptor pair
   function automatic logic pb_is_dual(pb_mode_e m, logic ep_zero, logic dir_in);
      logic r;
      unique case (m)
         PB_NONE:    r = 1'b0;
         PB_EP0_OUT: r = ep_zero & ~dir_in;
         PB_ALL:     r = 1'b1;
         default:    r = ~ep_zero;
      endcase
      return r;
   endfunction

   // Number of descriptors occupied in a given mode for n endpoints
   function automatic int pb_desc_count(pb_mode_e m, int n);
      int r;
      unique case (m)
         PB_NONE:    r = 2 * n;
         PB_EP0_OUT: r = 2 * n + 1;
         PB_ALL:     r = 4 * n;
         default:    r = 4 * n - 2;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ppbd_pointer_bank.sv
module ppbd_pointer_bank
   import usb_ppbd_pkg::*;
#(
   parameter int NUM_EP = 16,
   localparam int EP_W  = $clog2(NUM_EP),
   localparam int SLOTS = 2 * NUM_EP,
   localparam int SEL_W = EP_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [1:0]       mode,
   input  logic             done_vld,
   input  logic [EP_W-1:0]  done_ep,
   input  logic             done_dir,
   input  logic             swrst,
   output logic [SLOTS-1:0] ptr_q,
   output logic             last_odd_q
);

   initial begin
      assert (NUM_EP >= 2 && (NUM_EP & (NUM_EP - 1)) == 0)
         else $error("NUM_EP must be a power of two of at least 2");
   end

   pb_mode_e         mode_e;
   logic [1:0]       mode_q;
   logic             clear;
   logic             acc;
   logic             dual_done;
   logic [SEL_W-1:0] done_sel;
   logic [SLOTS-1:0] dual_mask;

   assign mode_e    = pb_mode_e'(mode);
   assign done_sel  = {done_ep, done_dir};
   assign clear     = swrst | ~enable | (mode != mode_q);
   assign acc       = done_vld & ~clear;
   assign dual_done = pb_is_dual(mode_e, done_ep == '0, done_dir);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= 2'b00;
      else        mode_q <= mode;
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam int  SEP  = s / 2;
      localparam logic SDIR = logic'(s % 2);
      logic bit_q;

      assign dual_mask[s] = pb_is_dual(mode_e, SEP == 0, SDIR);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (clear)
            bit_q <= 1'b0;
         else if (acc && dual_mask[s] && (done_sel == SEL_W'(s)))
            bit_q <= ~bit_q;
      end

      assign ptr_q[s] = bit_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         last_odd_q <= 1'b0;
      else if (acc)
         last_odd_q <= dual_done ? ptr_q[done_sel] : 1'b0;
   end

   // R8 R9 R12: any clearing event leaves every parity at Even
   a_r8_clear_even: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (ptr_q == '0));

   // R4: an accepted completion on a double-buffered pair flips exactly one parity
   a_r4_one_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && dual_done) |=> ($countones(ptr_q ^ $past(ptr_q)) == 1));

   // R6: a completion on a single-buffered pair reports Even
   a_r6_status_even: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !dual_done) |=> !last_odd_q);

   // R6: single-buffered pairs never hold Odd while the mode is steady
   a_r6_single_even: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == mode_q) |-> ((ptr_q & ~dual_mask) == '0));

endmodule

// File: rtl/ppbd_index_map.sv
module ppbd_index_map
   import usb_ppbd_pkg::*;
#(
   parameter int NUM_EP = 16,
   localparam int EP_W  = $clog2(NUM_EP),
   localparam int SLOTS = 2 * NUM_EP,
   localparam int IDX_W = $clog2(4 * NUM_EP)
) (
   input  logic [1:0]       mode,
   input  logic [EP_W-1:0]  look_ep,
   input  logic             look_dir,
   input  logic [SLOTS-1:0] ptr,
   output logic [IDX_W-1:0] idx
);

   pb_mode_e         mode_e;
   logic             par;
   logic [IDX_W-1:0] e;
   logic [IDX_W-1:0] d;
   logic [IDX_W-1:0] p;
   logic             ep_zero;

   assign mode_e  = pb_mode_e'(mode);
   assign par     = ptr[{look_ep, look_dir}];
   assign ep_zero = (look_ep == '0);
   assign e       = IDX_W'(look_ep);
   assign d       = IDX_W'(look_dir);
   assign p       = IDX_W'(par);

   always_comb begin
      unique case (mode_e)
         PB_NONE:
            idx = (e << 1) + d;
         PB_EP0_OUT:
            if (ep_zero) idx = look_dir ? IDX_W'(2) : p;
            else         idx = (e << 1) + d + IDX_W'(1);
         PB_ALL:
            idx = (e << 2) + (d << 1) + p;
         default:
            if (ep_zero) idx = d;
            else         idx = IDX_W'(2) + ((e - IDX_W'(1)) << 2) + (d << 1) + p;
      endcase
   end

endmodule

// File: rtl/ppbd_addr_gen.sv
module ppbd_addr_gen #(
   parameter int          IDX_W      = 6,
   parameter int          ADDR_W     = 16,
   parameter logic [31:0] TABLE_BASE = 32'h0000_0400,
   parameter int          DESC_BYTES = 4,
   localparam int         DSHIFT     = $clog2(DESC_BYTES),
   localparam bit         DPOW2      = ((1 << DSHIFT) == DESC_BYTES)
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);

   initial begin
      assert (DESC_BYTES >= 1) else $error("DESC_BYTES must be positive");
      assert (ADDR_W > IDX_W + DSHIFT) else $error("ADDR_W too narrow for the table");
   end

   logic [ADDR_W-1:0] offs;

   if (DPOW2) begin : g_shift
      assign offs = ADDR_W'(idx) << DSHIFT;
   end else begin : g_mult
      assign offs = ADDR_W'(idx) * ADDR_W'(DESC_BYTES);
   end

   assign addr = ADDR_W'(TABLE_BASE) + offs;

endmodule

// File: rtl/usb_ppbd_addresser.sv
module usb_ppbd_addresser
   import usb_ppbd_pkg::*;
#(
   parameter int          NUM_EP     = 16,
   parameter int          ADDR_W     = 16,
   parameter logic [31:0] TABLE_BASE = 32'h0000_0400,
   parameter int          DESC_BYTES = 4,
   localparam int         EP_W       = $clog2(NUM_EP),
   localparam int         IDX_W      = $clog2(4 * NUM_EP),
   localparam int         SLOTS      = 2 * NUM_EP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [1:0]        mode,
   input  logic              done_vld,
   input  logic [EP_W-1:0]   done_ep,
   input  logic              done_dir,
   input  logic              swrst,
   input  logic [EP_W-1:0]   look_ep,
   input  logic              look_dir,
   output logic [IDX_W-1:0]  look_idx,
   output logic [ADDR_W-1:0] look_addr,
   output logic              last_odd
);

   logic [SLOTS-1:0] ptr;

   ppbd_pointer_bank #(.NUM_EP(NUM_EP)) bank_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .mode       (mode),
      .done_vld   (done_vld),
      .done_ep    (done_ep),
      .done_dir   (done_dir),
      .swrst      (swrst),
      .ptr_q      (ptr),
      .last_odd_q (last_odd)
   );

   ppbd_index_map #(.NUM_EP(NUM_EP)) map_i (
      .mode     (mode),
      .look_ep  (look_ep),
      .look_dir (look_dir),
      .ptr      (ptr),
      .idx      (look_idx)
   );

   ppbd_addr_gen #(
      .IDX_W      (IDX_W),
      .ADDR_W     (ADDR_W),
      .TABLE_BASE (TABLE_BASE),
      .DESC_BYTES (DESC_BYTES)
   ) addr_i (
      .idx  (look_idx),
      .addr (look_addr)
   );

   // R11: lookups stay inside the descriptor count of the active mode
   a_r11_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      enable |-> (32'(look_idx) < pb_desc_count(pb_mode_e'(mode), NUM_EP)));

endmodule

// File: tb/usb_ppbd_addresser_tb.sv
`timescale 1ns/100ps
module usb_ppbd_addresser_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        enable;
   logic [1:0]  mode;
   logic        done_vld;
   logic [3:0]  done_ep;
   logic        done_dir;
   logic        swrst;
   logic [3:0]  look_ep;
   logic        look_dir;
   logic [5:0]  look_idx;
   logic [15:0] look_addr;
   logic        last_odd;

   int n_checks = 0;
   int n_fails  = 0;
   bit mdl_ptr [32];
   bit mdl_last;
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   usb_ppbd_addresser dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
      .done_vld(done_vld), .done_ep(done_ep), .done_dir(done_dir),
      .swrst(swrst), .look_ep(look_ep), .look_dir(look_dir),
      .look_idx(look_idx), .look_addr(look_addr), .last_odd(last_odd)
   );

   function automatic bit is_dual(int m, int e, int d);
      case (m)
         0: return 1'b0;
         1: return (e == 0 && d == 0);
         2: return 1'b1;
         default: return (e != 0);
      endcase
   endfunction

   function automatic int exp_idx(int m, int e, int d, int p);
      case (m)
         0: return 2 * e + d;
         1: return (e == 0) ? ((d == 0) ? p : 2) : 2 * e + d + 1;
         2: return 4 * e + 2 * d + p;
         default: return (e == 0) ? d : 2 + 4 * (e - 1) + 2 * d + p;
      endcase
   endfunction

   function automatic int count_of(int m);
      case (m)
         0: return 32;
         1: return 33;
         2: return 64;
         default: return 62;
      endcase
   endfunction

   task automatic check(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < 32; i++) mdl_ptr[i] = 1'b0;
   endtask

   task automatic sweep(string req);
      for (int e = 0; e < 16; e++) begin
         for (int d = 0; d < 2; d++) begin
            int ei;
            @(negedge clk);
            look_ep  = 4'(e);
            look_dir = 1'(d);
            #1;
            ei = exp_idx(int'(mode), e, d, int'(mdl_ptr[2 * e + d]));
            check(req, "index", int'(look_idx), ei);
            check("R10", "address", int'(look_addr), 'h400 + 4 * ei);
            check("R11", "in range", int'(int'(look_idx) < count_of(int'(mode))), 1);
         end
      end
   endtask

   // one completion pulse; sw = software clear in the same cycle
   task automatic complete(int e, int d, bit sw);
      @(negedge clk);
      done_vld = 1'b1;
      done_ep  = 4'(e);
      done_dir = 1'(d);
      swrst    = sw;
      @(negedge clk);
      done_vld = 1'b0;
      swrst    = 1'b0;
      if (sw || !enable) begin
         model_clear();
      end else if (is_dual(int'(mode), e, d)) begin
         mdl_last = mdl_ptr[2 * e + d];
         mdl_ptr[2 * e + d] = ~mdl_ptr[2 * e + d];
      end else begin
         mdl_last = 1'b0;
      end
      #1;
      if (sw) check("R8", "last_odd kept", int'(last_odd), int'(mdl_last));
      else if (!is_dual(int'(mode), e, d)) check("R6", "last_odd", int'(last_odd), int'(mdl_last));
      else check("R7", "last_odd", int'(last_odd), int'(mdl_last));
   endtask

   task automatic burst(int n);
      for (int i = 0; i < n; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         complete(int'(lfsr[3:0]), int'(lfsr[4]), 1'b0);
      end
   endtask

   initial begin
      #(200000 * 4);
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

   initial begin
      string mreq [4];
      mreq[0] = "R2"; mreq[1] = "R3"; mreq[2] = "R4"; mreq[3] = "R5";
      rst_n = 1'b0; enable = 1'b0; mode = 2'b00; done_vld = 1'b0;
      done_ep = '0; done_dir = 1'b0; swrst = 1'b0; look_ep = '0; look_dir = 1'b0;
      model_clear();
      mdl_last = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check("R1", "last_odd after reset", int'(last_odd), 0);
      enable = 1'b1;
      @(negedge clk);
      sweep("R1");

      // every mode: clean sweep, completions, sweep with mixed parities
      for (int m = 0; m < 4; m++) begin
         @(negedge clk);
         mode = 2'(m);
         @(negedge clk);
         model_clear();
         sweep(mreq[m]);
         burst(60);
         sweep(mreq[m]);
         complete(0, 1, 1'b0);
         complete(0, 0, 1'b0);
         complete(0, 0, 1'b0);
         complete(15, 1, 1'b0);
         sweep(mreq[m]);
      end

      // R8: software clear collides with a completion
      @(negedge clk);
      mode = 2'b10;
      @(negedge clk);
      model_clear();
      burst(50);
      complete(7, 1, 1'b1);
      sweep("R8");

      // R9: mode write collides with a completion
      burst(50);
      @(negedge clk);
      mode     = 2'b11;
      done_vld = 1'b1;
      done_ep  = 4'd5;
      done_dir = 1'b0;
      @(negedge clk);
      done_vld = 1'b0;
      model_clear();
      #1;
      check("R9", "last_odd kept", int'(last_odd), int'(mdl_last));
      sweep("R9");

      // R12: disable clears and ignores completions
      @(negedge clk);
      mode = 2'b10;
      @(negedge clk);
      model_clear();
      burst(50);
      @(negedge clk);
      enable = 1'b0;
      complete(3, 1, 1'b0);
      check("R12", "last_odd while disabled", int'(last_odd), int'(mdl_last));
      @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
      sweep("R12");

      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

endmodule